// File: doc/BRIEF.md
# Recursive Parallel-Prefix Binary Adder

This block adds two unsigned operands of a power-of-two width and returns the sum together with a carry out. It has no carry input. It is purely combinational. All carries are found at once by a prefix network rather than by a ripple chain.

Each bit position first forms a generate flag and a propagate flag. The generate flag is the AND of the operand bits, and the propagate flag is their XOR. The network combines adjacent groups with an associative merge. A lower group followed by a higher group yields the following merged pair:

- generate: the higher generate, OR the lower generate AND the higher propagate.
- propagate: the AND of the two propagates.

The network is built by splitting the bit range in half. It solves each half on its own, then merges the lower half's total into every position of the upper half. Unrolled, this gives log2(N) levels with N/2 merge cells per level.

The prefix generate at position i is the carry out of bit i. The sum bit at position 0 is the propagate at position 0. The sum bit at any higher position i is the propagate at i XOR the carry out of bit i-1.

The block has no sequential behaviour, so it has no states or transitions. The single path is settled inputs → per-bit flags → prefix levels → sum stage.

Top module: `pp_adder`

## Requirements
- R1: For any operands, the concatenation {carry_out, sum_out} equals the (N+1)-bit arithmetic sum of a_in and b_in.
- R2: carry_out is 1 exactly when a_in + b_in exceeds 2^N - 1. For example, all ones plus one gives sum_out = 0 with carry_out = 1.
- R3: sum_out bit 0 equals a_in bit 0 XOR b_in bit 0, because no carry enters at position 0.
- R4: The carry out of every bit i ≥ 1 equals that bit's generate OR (that bit's propagate AND the carry out of bit i-1). As a result, a carry generated at bit 0 travels through any run of propagating bits up to the first non-propagating bit.
- R5: When every bit propagates (b_in is the bitwise inverse of a_in), sum_out is all ones and carry_out is 0.
- R6: With both operands zero, both outputs are zero.
- R7: For alternating patterns, the outputs match the arithmetic sum. With a_in = 0xAAAA_AAAA at the default width, adding b_in = 0x5555_5555 gives 0x0_FFFF_FFFF, and adding a_in to itself gives 0x1_5555_5554.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | N | First operand |
| b_in | input | N | Second operand |
| sum_out | output | N | Low N bits of the sum |
| carry_out | output | 1 | Carry out of the top bit |

## Verification
The hardest case is a carry that must cross the full width. Here a generate at bit 0 meets an unbroken run of propagating bits, and only the top merge level can deliver it. Random operands almost never produce this. The stimulus therefore sweeps a low mask of every length from 1 to N, adds one to each, and uses the all-ones plus one case. These walk the carry to every position, including each half boundary that the recursion merges across.

// File: rtl/pp_adder_pkg.sv
package pp_adder_pkg;

    typedef struct packed {
        logic g;
        logic p;
    } gp_t;

    // Merge a lower-order group with the higher-order group that follows it.
    function automatic gp_t gp_merge(gp_t lo, gp_t hi);
        gp_t r;
        r.g = hi.g | (lo.g & hi.p);
        r.p = hi.p & lo.p;
        return r;
    endfunction

endpackage

// File: rtl/pp_gp_gen.sv
module pp_gp_gen
    import pp_adder_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output gp_t  [N-1:0] bit_gp
);

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign bit_gp[i].g = a_in[i] & b_in[i];
        assign bit_gp[i].p = a_in[i] ^ b_in[i];
    end

endmodule

// File: rtl/pp_gp_cell.sv
module pp_gp_cell
    import pp_adder_pkg::*;
(
    input  gp_t lo_in,
    input  gp_t hi_in,
    output gp_t merged
);

    assign merged = gp_merge(lo_in, hi_in);

endmodule

// File: rtl/pp_prefix_net.sv
module pp_prefix_net
    import pp_adder_pkg::*;
#(
    parameter int N = 32
) (
    input  gp_t [N-1:0] bit_gp,
    output gp_t [N-1:0] grp_gp
);

    localparam int LV = $clog2(N);

    gp_t [N-1:0] stage [0:LV];

    assign stage[0] = bit_gp;

    // Level l unrolls the half-split recursion on blocks of 2^(l+1) bits.
    // Every position in an upper half merges with the last position of
    // the matching lower half.
    for (genvar l = 0; l < LV; l++) begin : g_lvl
        for (genvar i = 0; i < N; i++) begin : g_pos
            localparam int BLK  = 1 << (l + 1);
            localparam int HALF = 1 << l;
            localparam int JOIN = ((i / BLK) * BLK) + HALF - 1;
            if (((i / HALF) % 2) == 1) begin : g_merge
                pp_gp_cell u_cell (
                    .lo_in  (stage[l][JOIN]),
                    .hi_in  (stage[l][i]),
                    .merged (stage[l+1][i])
                );
            end else begin : g_pass
                assign stage[l+1][i] = stage[l][i];
            end
        end
    end

    assign grp_gp = stage[LV];

endmodule

// File: rtl/pp_sum_gen.sv
module pp_sum_gen
    import pp_adder_pkg::*;
#(
    parameter int N = 32
) (
    input  gp_t  [N-1:0] bit_gp,
    input  gp_t  [N-1:0] grp_gp,
    output logic [N-1:0] sum_out,
    output logic         carry_out
);

    assign sum_out[0] = bit_gp[0].p;

    for (genvar i = 1; i < N; i++) begin : g_sum
        assign sum_out[i] = bit_gp[i].p ^ grp_gp[i-1].g;
    end

    assign carry_out = grp_gp[N-1].g;

endmodule

// File: rtl/pp_adder.sv
module pp_adder
    import pp_adder_pkg::*;
#(
    parameter int N = 32
) (
    input  logic [N-1:0] a_in,
    input  logic [N-1:0] b_in,
    output logic [N-1:0] sum_out,
    output logic         carry_out
);

    gp_t [N-1:0] bit_gp;
    gp_t [N-1:0] grp_gp;
    logic [N-1:0] all_p;

    pp_gp_gen #(.N(N)) u_gp (
        .a_in   (a_in),
        .b_in   (b_in),
        .bit_gp (bit_gp)
    );

    pp_prefix_net #(.N(N)) u_net (
        .bit_gp (bit_gp),
        .grp_gp (grp_gp)
    );

    pp_sum_gen #(.N(N)) u_sum (
        .bit_gp    (bit_gp),
        .grp_gp    (grp_gp),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    for (genvar i = 0; i < N; i++) begin : g_allp
        assign all_p[i] = bit_gp[i].p;
    end

    always_comb begin
        // R1
        sum_match_chk: assert ({carry_out, sum_out} == ({1'b0, a_in} + {1'b0, b_in}));
        // R5
        if (&all_p) begin
            all_prop_chk: assert (!carry_out && (&sum_out));
        end
        for (int i = 0; i < N; i++) begin
            // R4
            grp_excl_chk: assert (!(grp_gp[i].g && grp_gp[i].p));
        end
        for (int i = 1; i < N; i++) begin
            // R4
            ripple_rel_chk: assert (grp_gp[i].g == (bit_gp[i].g | (bit_gp[i].p & grp_gp[i-1].g)));
        end
    end

endmodule

// File: tb/pp_adder_tb.sv
module pp_adder_tb;

    localparam int W = 32;
    localparam int NV = 10;

    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic [W:0]   s;
    } vec_t;

    localparam vec_t VECS [0:NV-1] = '{
        '{32'h0000_0000, 32'h0000_0000, 33'h0_0000_0000}, // R6
        '{32'hFFFF_FFFF, 32'h0000_0001, 33'h1_0000_0000}, // R2
        '{32'hAAAA_AAAA, 32'h5555_5555, 33'h0_FFFF_FFFF}, // R7 R5
        '{32'hAAAA_AAAA, 32'hAAAA_AAAA, 33'h1_5555_5554}, // R7
        '{32'h5555_5555, 32'h5555_5555, 33'h0_AAAA_AAAA}, // R7
        '{32'hFFFF_FFFF, 32'hFFFF_FFFF, 33'h1_FFFF_FFFE}, // R2
        '{32'h8000_0000, 32'h8000_0000, 33'h1_0000_0000}, // R2
        '{32'h1234_5678, 32'h9ABC_DEF0, 33'h0_ACF1_3568}, // R1
        '{32'h7FFF_FFFF, 32'h0000_0001, 33'h0_8000_0000}, // R4
        '{32'h0000_FFFF, 32'h0000_0001, 33'h0_0001_0000}  // R4
    };

    logic clk = 1'b0;
    logic [W-1:0] a_in = '0;
    logic [W-1:0] b_in = '0;
    logic [W-1:0] sum_out;
    logic         carry_out;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pp_adder #(.N(W)) u_dut (
        .a_in      (a_in),
        .b_in      (b_in),
        .sum_out   (sum_out),
        .carry_out (carry_out)
    );

    task automatic apply_chk(string req, logic [W-1:0] a, logic [W-1:0] b, logic [W:0] exp);
        @(negedge clk);
        a_in = a;
        b_in = b;
        #1;
        checks++;
        if ({carry_out, sum_out} !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h actual=%h expected=%h", req, a, b, {carry_out, sum_out}, exp);
        end
    endtask

    initial begin
        // R6 state with zero inputs
        #1;
        checks++;
        if ({carry_out, sum_out} !== '0) begin
            errors++;
            $display("FAIL R6 actual=%h expected=0", {carry_out, sum_out});
        end
        for (int k = 0; k < NV; k++) begin
            apply_chk("R1 table", VECS[k].a, VECS[k].b, VECS[k].s);
        end
        // R4: carry from bit 0 through a propagate run of every length
        for (int k = 0; k < W; k++) begin
            logic [W-1:0] m = (k == W - 1) ? '1 : ((W'(1) << (k + 1)) - W'(1));
            apply_chk("R4 chain", m, W'(1), {1'b0, m} + (W + 1)'(1));
        end
        // R5: all bits propagate
        for (int k = 0; k < 8; k++) begin
            logic [W-1:0] r = $urandom();
            apply_chk("R5 inverse", r, ~r, {1'b0, {W{1'b1}}});
        end
        // R3: bit 0 has no carry in
        for (int k = 0; k < 4; k++) begin
            logic [W-1:0] r = $urandom();
            logic [W-1:0] q = $urandom();
            @(negedge clk);
            a_in = r;
            b_in = q;
            #1;
            checks++;
            if (sum_out[0] !== (r[0] ^ q[0])) begin
                errors++;
                $display("FAIL R3 actual=%b expected=%b", sum_out[0], r[0] ^ q[0]);
            end
        end
        // R1 R2: random operands
        for (int k = 0; k < 200; k++) begin
            logic [W-1:0] r = $urandom();
            logic [W-1:0] q = $urandom();
            apply_chk("R1 R2 random", r, q, {1'b0, r} + {1'b0, q});
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule